// File: doc/BRIEF.md
# XGMII Start-of-Frame Word Aligner

This block sits on the receive side of a 10G Ethernet path. It accepts a single-data-rate XGMII word stream: 64 data bits and 8 control bits per 156.25 MHz cycle, one control bit per byte lane. It re-packs that stream so that every frame's start character lands in byte lane 0 of an output word. A start character can arrive in lane 0 or in the middle lane. In the second case the block builds each output word from the upper half of one input word and the lower half of the next. That choice stays fixed until the word carrying the terminate character has gone out.

Downstream logic, for example a trigger matcher or a capture serializer feeding a logic analyser, can then decode fields at fixed byte offsets without knowing how the frame arrived. The lane count and lane width are parameters, so later designs can place several instances side by side on a wider multi-lane path. The input must separate frames by at least one word made entirely of idle characters.

Top module: `sof_lane_aligner`

## Requirements
- R1: While reset is high, and on the first sampled output after it, every output byte is the idle character 0x07 with all control bits set, and out_valid and out_sof are low.
- R2: A start character (0xFB with its control bit set) in lane 0 of an input word during a gap makes that word appear unchanged on the output one cycle later. The following words of the frame also pass through unchanged with one cycle of latency.
- R3: A start character in lane LANES/2 (lane 4) during a gap makes the block shift lanes. Output word k of the frame takes input word w+k lanes 4..7 in its lanes 0..3, and input word w+k+1 lanes 0..3 in its lanes 4..7. Here w is the word holding the start character. Word 0 appears two cycles after word w was presented.
- R4: The output produced for the input word that carries a lane-4 start is a full idle word with out_valid low.
- R5: The shift chosen at the start is held until the output word containing a terminate character (0xFD with its control bit set) has been sent. The next word has out_valid low. A 0xFD byte whose control bit is clear is ordinary data.
- R6: out_sof is high only on the first output word of each frame, together with out_valid, and that word carries 0xFB with its control bit set in lane 0.
- R7: Between frames the idle input words pass to the output unchanged, with out_valid and out_sof low.
- R8: Inside a frame, error characters (0xFE, control set) and stray start characters are forwarded in their shifted positions. They do not change the shift or restart the frame.
- R9: A frame whose start and terminate fall in one output word yields a single word with out_valid and out_sof high, followed by an idle word with out_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | LANES*LANE_W | Unaligned data word, lane 0 in the low byte |
| in_ctrl | input | LANES | Control flag per input lane |
| out_data | output | LANES*LANE_W | Aligned data word |
| out_ctrl | output | LANES | Control flag per output lane |
| out_valid | output | 1 | Output word belongs to a frame |
| out_sof | output | 1 | Output word is the first of a frame |

## Verification
A frame whose start character is in lane 0 shows up on the output one cycle after its first input word. A lane-4 frame shows up two cycles after, and the cycle between carries the idle word of R4. The bench builds the full expected output stream while it generates the input stream: each frame's bytes go into the expected array at the start word index plus that lane's latency. Inputs change on the falling edge, and sample n is compared with expected word n, which is the result of the rising edge that captured input word n-1. Frames are a few fixed corner cases plus random lengths, start lanes and error characters drawn with a fixed seed.

// File: rtl/sofa_pkg.sv
package sofa_pkg;

   // control code points recognised by the aligner
   localparam logic [7:0] XC_START = 8'hFB;
   localparam logic [7:0] XC_TERM  = 8'hFD;
   localparam logic [7:0] XC_IDLE  = 8'h07;
   localparam logic [7:0] XC_ERROR = 8'hFE;

   typedef enum logic [1:0] {
      AL_IDLE    = 2'd0,
      AL_ARMED   = 2'd1,
      AL_DIRECT  = 2'd2,
      AL_SHIFTED = 2'd3
   } align_state_e;

endpackage

// File: rtl/sofa_char_find.sv
module sofa_char_find #(
   parameter int              LANES  = 8,
   parameter int              LANE_W = 8,
   parameter logic [7:0]      CHAR   = 8'hFB,
   parameter logic [LANES-1:0] MASK  = '1
) (
   input  logic [LANES*LANE_W-1:0] data,
   input  logic [LANES-1:0]        ctrl,
   output logic [LANES-1:0]        hit
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (MASK[g]) begin : g_live
         assign hit[g] = ctrl[g] && (data[g*LANE_W +: LANE_W] == LANE_W'(CHAR));
      end else begin : g_dead
         assign hit[g] = 1'b0;
      end
   end

endmodule

// File: rtl/sofa_lane_mux.sv
module sofa_lane_mux #(
   parameter int LANES  = 8,
   parameter int LANE_W = 8
) (
   input  logic                          shift,
   input  logic [LANES*LANE_W-1:0]       cur_d,
   input  logic [LANES-1:0]              cur_c,
   input  logic [(LANES/2)*LANE_W-1:0]   prev_hi_d,
   input  logic [LANES/2-1:0]            prev_hi_c,
   output logic [LANES*LANE_W-1:0]       form_d,
   output logic [LANES-1:0]              form_c
);

   localparam int HALF = LANES / 2;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g < HALF) begin : g_low
         // low output lanes come from the upper half of the older word
         assign form_d[g*LANE_W +: LANE_W] = shift ? prev_hi_d[g*LANE_W +: LANE_W]
                                                   : cur_d[g*LANE_W +: LANE_W];
         assign form_c[g] = shift ? prev_hi_c[g] : cur_c[g];
      end else begin : g_high
         // high output lanes come from the lower half of the newer word
         assign form_d[g*LANE_W +: LANE_W] = shift ? cur_d[(g-HALF)*LANE_W +: LANE_W]
                                                   : cur_d[g*LANE_W +: LANE_W];
         assign form_c[g] = shift ? cur_c[g-HALF] : cur_c[g];
      end
   end

endmodule

// File: rtl/sof_lane_aligner.sv
module sof_lane_aligner
   import sofa_pkg::*;
#(
   parameter int LANES  = 8,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [LANES*LANE_W-1:0] in_data,
   input  logic [LANES-1:0]        in_ctrl,
   output logic [LANES*LANE_W-1:0] out_data,
   output logic [LANES-1:0]        out_ctrl,
   output logic                    out_valid,
   output logic                    out_sof
);

   localparam int DW   = LANES * LANE_W;
   localparam int HALF = LANES / 2;
   localparam int HW   = HALF * LANE_W;
   localparam logic [DW-1:0]    IDLE_WORD  = {LANES{LANE_W'(XC_IDLE)}};
   localparam logic [LANES-1:0] START_MASK = LANES'(1) | (LANES'(1) << HALF);

   if (LANE_W != 8) begin : g_bad_width
      $error("sof_lane_aligner: LANE_W must be 8");
   end
   if ((LANES < 2) || ((LANES % 2) != 0)) begin : g_bad_lanes
      $error("sof_lane_aligner: LANES must be even and at least 2");
   end

   align_state_e state, nxt;

   logic [HW-1:0]    prev_hi_d;
   logic [HALF-1:0]  prev_hi_c;
   logic [DW-1:0]    form_d, d_n;
   logic [LANES-1:0] form_c, c_n;
   logic [LANES-1:0] start_hit, term_hit;
   logic             shift_sel, s_low, s_high, term_any, v_n, sof_n;

   assign shift_sel = (state == AL_ARMED) || (state == AL_SHIFTED);

   sofa_lane_mux #(.LANES(LANES), .LANE_W(LANE_W)) u_mux (
      .shift     (shift_sel),
      .cur_d     (in_data),
      .cur_c     (in_ctrl),
      .prev_hi_d (prev_hi_d),
      .prev_hi_c (prev_hi_c),
      .form_d    (form_d),
      .form_c    (form_c)
   );

   sofa_char_find #(.LANES(LANES), .LANE_W(LANE_W), .CHAR(XC_START),
                    .MASK(START_MASK)) u_start (
      .data (in_data),
      .ctrl (in_ctrl),
      .hit  (start_hit)
   );

   sofa_char_find #(.LANES(LANES), .LANE_W(LANE_W), .CHAR(XC_TERM),
                    .MASK('1)) u_term (
      .data (form_d),
      .ctrl (form_c),
      .hit  (term_hit)
   );

   assign s_low    = start_hit[0];
   assign s_high   = |start_hit[LANES-1:1];
   assign term_any = |term_hit;

   always_comb begin
      nxt   = state;
      d_n   = form_d;
      c_n   = form_c;
      v_n   = 1'b0;
      sof_n = 1'b0;
      unique case (state)
         AL_IDLE: begin
            if (s_low) begin
               v_n   = 1'b1;
               sof_n = 1'b1;
               nxt   = term_any ? AL_IDLE : AL_DIRECT;
            end else if (s_high) begin
               d_n = IDLE_WORD;
               c_n = '1;
               nxt = AL_ARMED;
            end
         end
         AL_ARMED: begin
            v_n   = 1'b1;
            sof_n = 1'b1;
            nxt   = term_any ? AL_IDLE : AL_SHIFTED;
         end
         default: begin
            v_n = 1'b1;
            if (term_any) nxt = AL_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= AL_IDLE;
         prev_hi_d <= IDLE_WORD[DW-1:HW];
         prev_hi_c <= '1;
         out_data  <= IDLE_WORD;
         out_ctrl  <= '1;
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
      end else begin
         state     <= nxt;
         prev_hi_d <= in_data[DW-1:HW];
         prev_hi_c <= in_ctrl[LANES-1:HALF];
         out_data  <= d_n;
         out_ctrl  <= c_n;
         out_valid <= v_n;
         out_sof   <= sof_n;
      end
   end

endmodule

// File: rtl/sof_lane_aligner_chk.sv
module sof_lane_aligner_chk
   import sofa_pkg::*;
#(
   parameter int LANES  = 8,
   parameter int LANE_W = 8
) (
   input logic                    clk,
   input logic                    rst,
   input logic [LANES*LANE_W-1:0] out_data,
   input logic [LANES-1:0]        out_ctrl,
   input logic                    out_valid,
   input logic                    out_sof
);

   logic term_out;

   always_comb begin
      term_out = 1'b0;
      for (int i = 0; i < LANES; i++) begin
         if (out_ctrl[i] && (out_data[i*LANE_W +: LANE_W] == LANE_W'(XC_TERM))) term_out = 1'b1;
      end
   end

   // R6
   sof_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
      out_sof |-> out_valid);

   // R6
   sof_lane0_start_chk: assert property (@(posedge clk) disable iff (rst)
      out_sof |-> (out_ctrl[0] && (out_data[LANE_W-1:0] == LANE_W'(XC_START))));

   // R5
   term_ends_frame_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && term_out) |=> !out_valid);

   // R5
   frame_contiguous_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_sof) |-> $past(out_valid));

   // R7
   gap_all_control_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (out_ctrl == '1));

endmodule

bind sof_lane_aligner sof_lane_aligner_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .out_data  (out_data),
   .out_ctrl  (out_ctrl),
   .out_valid (out_valid),
   .out_sof   (out_sof)
);

// File: tb/sof_lane_aligner_test.sv
module sof_lane_aligner_test;

   localparam int LN   = 8;
   localparam int DW   = 64;
   localparam int MAXW = 700;
   localparam logic [DW-1:0] IDLE_D = {LN{8'h07}};

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [DW-1:0] in_data;
   logic [LN-1:0] in_ctrl;
   logic [DW-1:0] out_data;
   logic [LN-1:0] out_ctrl;
   logic          out_valid, out_sof;

   always #10 clk = ~clk;

   sof_lane_aligner #(.LANES(LN), .LANE_W(8)) uut (
      .clk(clk), .rst(rst), .in_data(in_data), .in_ctrl(in_ctrl),
      .out_data(out_data), .out_ctrl(out_ctrl), .out_valid(out_valid), .out_sof(out_sof)
   );

   logic [DW-1:0] iw [MAXW];
   logic [LN-1:0] ic [MAXW];
   logic [DW-1:0] ew [MAXW];
   logic [LN-1:0] ec [MAXW];
   logic          ev [MAXW];
   logic          es [MAXW];
   string         etag [MAXW];

   int pos    = 0;
   int n_cmp  = 0;
   int n_bad  = 0;
   int nwords = 0;
   bit done   = 1'b0;

   task automatic put_in(input logic [7:0] b, input logic c, input int p);
      iw[p/8][(p%8)*8 +: 8] = b;
      ic[p/8][p%8] = c;
   endtask

   task automatic put_exp(input logic [7:0] b, input logic c, input int p);
      ew[p/8][(p%8)*8 +: 8] = b;
      ec[p/8][p%8] = c;
   endtask

   // lane: start lane (0 or 4); plen: payload bytes; special: inject stray codes
   task automatic add_frame(input int lane, input int plen, input bit special);
      logic [7:0] fb [64];
      logic       fc [64];
      int n, w, ow, nw;
      n = plen + 2;
      fb[0] = 8'hFB; fc[0] = 1'b1;
      for (int j = 1; j <= plen; j++) begin
         fb[j] = 8'($urandom);
         fc[j] = 1'b0;
         if (!special && ($urandom % 12 == 0)) begin
            fb[j] = 8'hFE; fc[j] = 1'b1;
         end
      end
      if (special && plen >= 6) begin
         fb[1] = 8'hFD; fc[1] = 1'b0;   // data byte, not a terminate (R5)
         fb[3] = 8'hFE; fc[3] = 1'b1;   // error code mid-frame (R8)
         fb[5] = 8'hFB; fc[5] = 1'b1;   // stray start mid-frame (R8)
      end
      fb[n-1] = 8'hFD; fc[n-1] = 1'b1;
      pos += lane;
      w  = pos / 8;
      ow = w + ((lane == 0) ? 1 : 2);
      nw = (n + 7) / 8;
      if (lane != 0) etag[w+1] = "R4 idle word for lane-4 start";
      for (int j = 0; j < n; j++) begin
         put_in(fb[j], fc[j], pos + j);
         put_exp(fb[j], fc[j], ow*8 + j);
         ev[ow + j/8] = 1'b1;
         if (special)        etag[ow + j/8] = "R8 stray codes forwarded";
         else if (lane == 0) etag[ow + j/8] = "R2 direct frame word";
         else                etag[ow + j/8] = "R3 shifted frame word";
      end
      es[ow] = 1'b1;
      if (nw == 1) etag[ow] = "R9 single-word frame";
      else begin
         etag[ow] = "R6 first frame word";
         etag[ow+nw-1] = "R5 terminate word";
      end
      pos += n;
      pos = ((pos + 7) / 8) * 8 + 16;
   endtask

   task automatic cmp(input string tag, input logic [DW-1:0] xd, input logic [LN-1:0] xc,
                      input logic xv, input logic xs);
      n_cmp++;
      if (out_data !== xd || out_ctrl !== xc || out_valid !== xv || out_sof !== xs) begin
         n_bad++;
         $display("FAIL %s: got d=%h c=%h v=%b s=%b, expected d=%h c=%h v=%b s=%b",
                  tag, out_data, out_ctrl, out_valid, out_sof, xd, xc, xv, xs);
      end
   endtask

   initial begin
      void'($urandom(32'h5EED0A11));
      for (int i = 0; i < MAXW; i++) begin
         iw[i] = IDLE_D; ic[i] = '1;
         ew[i] = IDLE_D; ec[i] = '1;
         ev[i] = 1'b0;   es[i] = 1'b0;
         etag[i] = "R7 idle between frames";
      end
      pos = 16;
      // directed corner cases
      add_frame(0, 0, 1'b0);    // R9 start+terminate in one lane-0 word
      add_frame(4, 2, 1'b0);    // R9 whole frame in first shifted word
      add_frame(4, 20, 1'b1);   // R8 shifted with stray codes
      add_frame(0, 6, 1'b0);    // R5 terminate in last lane
      add_frame(4, 10, 1'b0);   // R3 two shifted words
      add_frame(0, 30, 1'b1);   // R8 direct with stray codes
      while (pos / 8 < MAXW - 14) begin
         add_frame((($urandom % 2) != 0) ? 4 : 0, int'($urandom % 48), 1'b0);
      end
      nwords = pos / 8;

      in_data = IDLE_D;
      in_ctrl = '1;
      repeat (3) @(negedge clk);
      cmp("R1 reset state", IDLE_D, '1, 1'b0, 1'b0);
      rst     = 1'b0;
      in_data = iw[0];
      in_ctrl = ic[0];
      for (int i = 1; i < nwords + 3; i++) begin
         @(negedge clk);
         cmp(etag[i], ew[i], ec[i], ev[i], es[i]);
         in_data = (i < nwords) ? iw[i] : IDLE_D;
         in_ctrl = (i < nwords) ? ic[i] : '1;
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule